// File: doc/BRIEF.md
# Mailbox Receive Queue

This block is the receiving end of a mailbox between processor cores. A remote agent pushes entries through a push port. Each entry carries an 8-bit source identifier and a 64-bit message. The entries sit in a circular queue of `DEPTH` slots.

Local software reads the oldest entry through three word registers and removes it by writing a pop command. A status word gives the raw read pointer, the raw write pointer and a full bit, so software can work out how many entries are waiting:
- when the write pointer is ahead of the read pointer, the count is write minus read;
- after the write pointer has wrapped, the count is depth minus read plus write;
- when the two pointers are equal, the full bit decides between zero and depth.

A level-style pending bit drives the interrupt output while entries wait and the source is unmasked. Software clears it by writing a one.

Top module: `mbox_rx_fifo`

## Requirements
- R1: A push with `push_valid` high is stored at the write pointer when the queue is not full, and the write pointer then advances modulo `DEPTH`. `push_full` is high exactly when `DEPTH` entries are held, and a push at that time is refused with no change to the queue.
- R2: A read at 0x00 returns the head source ID in bits [7:0]. A read at 0x04 returns message bits [31:0] and a read at 0x08 returns message bits [63:32]. All three read as zero when the queue is empty.
- R3: A write to 0x0C with bit 0 set removes the head entry and advances the read pointer modulo `DEPTH`. Such a write with bit 0 clear, or one made while the queue is empty, is ignored.
- R4: A read at 0x14 returns bit 0 = full, [23:16] = write pointer and [31:24] = read pointer, with every other bit zero.
- R5: A read at 0x24 returns `DEPTH`-1.
- R6: A write of zero to 0x10 empties the queue, setting both pointers to 0 and clearing full. It wins over a push or pop in the same cycle. A write of any non-zero value there is ignored.
- R7: The mask register at 0x1C is 5 bits wide, reads back in bits [4:0], and resets to 5'h1F. While mask bit 0 is 1, the pending bit does not set.
- R8: The pending bit (read at 0x18 bit 0, and driven on `irq`) sets in the cycle after one in which the queue is non-empty and mask bit 0 is 0. Writing 1 to bit 0 of 0x18 clears it. If entries remain and the source is still unmasked, it sets again one cycle later.
- R9: After reset the queue is empty, both pointers are 0, full is 0, `irq` is 0 and the mask is 5'h1F.
- R10: A push and a pop in the same cycle both take effect when the queue is not full. When the queue is full, the pop takes effect and the push is still refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| push_valid | input | 1 | Remote push request |
| push_id | input | 8 | Source ID of the pushed entry |
| push_msg | input | 64 | Message of the pushed entry |
| push_full | output | 1 | Queue full; pushes are refused |
| irq | output | 1 | Not-empty interrupt pending |

## Verification
A wrong pointer or a wrong full bit becomes visible in the status word and on `push_full` in the same cycle it is wrong. A slot that was written wrongly only shows up when it reaches the head, which may be up to `DEPTH`-1 pops later.

A pending bit that is set or cleared at the wrong moment appears on `irq` one cycle after the cause. For this reason the reference model is compared on every clock, for every output and for whatever register address is being driven. Clears are aimed at cycles where entries remain, so that a missing re-set is caught.

// File: rtl/mbox_rx_fifo.sv
module mbox_rx_fifo #(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wen,
  input  logic [5:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        push_valid,
  input  logic [7:0]  push_id,
  input  logic [63:0] push_msg,
  output logic        push_full,
  output logic        irq
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int EW = 8 + 64;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  localparam logic [5:0] A_ID   = 6'h00;
  localparam logic [5:0] A_LO   = 6'h04;
  localparam logic [5:0] A_HI   = 6'h08;
  localparam logic [5:0] A_POP  = 6'h0C;
  localparam logic [5:0] A_CLR  = 6'h10;
  localparam logic [5:0] A_STAT = 6'h14;
  localparam logic [5:0] A_PEND = 6'h18;
  localparam logic [5:0] A_MASK = 6'h1C;
  localparam logic [5:0] A_DEP  = 6'h24;

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          full, pend;
  logic [4:0]    mask;

  wire empty  = (wr_ptr == rd_ptr) && !full;
  wire rst_wr = reg_wen && reg_addr == A_CLR && reg_wdata == 32'd0;
  wire pop_wr = reg_wen && reg_addr == A_POP && reg_wdata[0];
  wire clr_wr = reg_wen && reg_addr == A_PEND && reg_wdata[0];
  wire push   = push_valid && !full && !rst_wr;
  wire pop    = pop_wr && !empty && !rst_wr;

  wire [PW-1:0] wr_nxt = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
  wire [PW-1:0] rd_nxt = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
  wire [EW-1:0] head   = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= {push_id, push_msg};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      full   <= 1'b0;
    end else if (rst_wr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      full   <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_nxt;
      if (pop)  rd_ptr <= rd_nxt;
      if (push && !pop && wr_nxt == rd_ptr) full <= 1'b1;
      else if (pop && !push)                full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= 5'h1F;
      pend <= 1'b0;
    end else begin
      if (reg_wen && reg_addr == A_MASK) mask <= reg_wdata[4:0];
      pend <= clr_wr ? 1'b0 : (pend || (!empty && !mask[0]));
    end
  end

  always_comb begin
    case (reg_addr)
      A_ID:    reg_rdata = {24'd0, head[EW-1 -: 8]};
      A_LO:    reg_rdata = head[31:0];
      A_HI:    reg_rdata = head[63:32];
      A_STAT:  reg_rdata = {8'(rd_ptr), 8'(wr_ptr), 15'd0, full};
      A_PEND:  reg_rdata = {31'd0, pend};
      A_MASK:  reg_rdata = {27'd0, mask};
      A_DEP:   reg_rdata = 32'(DEPTH - 1);
      default: reg_rdata = 32'd0;
    endcase
  end

  assign push_full = full;
  assign irq       = pend;

  assert_full_refuses_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_valid && !rst_wr && !pop_wr) |=> (wr_ptr == $past(wr_ptr) && full));
  assert_ptr_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr <= LAST && rd_ptr <= LAST));
  assert_empty_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop_wr && !push_valid) |=> (rd_ptr == $past(rd_ptr) && empty));
  assert_full_ptrs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (wr_ptr == rd_ptr));
  assert_fifo_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_wr |=> (wr_ptr == '0 && rd_ptr == '0 && !full));
  assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && mask[0]) |=> !pend);
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> !irq);
endmodule

// File: tb/mbox_rx_fifo_bench.sv
module mbox_rx_fifo_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wen = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        push_valid = 1'b0;
  logic [7:0]  push_id = '0;
  logic [63:0] push_msg = '0;
  logic        push_full, irq;

  mbox_rx_fifo #(.DEPTH(DEPTH)) u_mbox_rx_fifo (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .push_valid(push_valid),
    .push_id(push_id), .push_msg(push_msg), .push_full(push_full), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [71:0] q[$];
  int wp = 0, rp = 0;
  logic m_pend = 1'b0;
  logic [4:0] m_mask = 5'h1F;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [71:0] h;
    logic [31:0] e;
    string req;
    h = (q.size() == 0) ? '0 : q[0];
    case (reg_addr)
      6'h00: begin e = {24'd0, h[71:64]}; req = "R2"; end
      6'h04: begin e = h[31:0]; req = "R2"; end
      6'h08: begin e = h[63:32]; req = "R2"; end
      6'h14: begin e = {8'(rp), 8'(wp), 15'd0, q.size() == DEPTH}; req = "R4"; end
      6'h18: begin e = {31'd0, m_pend}; req = "R8"; end
      6'h1C: begin e = {27'd0, m_mask}; req = "R7"; end
      6'h24: begin e = 32'(DEPTH - 1); req = "R5"; end
      default: begin e = 32'd0; req = "R4"; end
    endcase
    chk(req, $sformatf("rdata@%h", reg_addr), reg_rdata, e);
    chk("R1", "push_full", {31'd0, push_full}, {31'd0, q.size() == DEPTH});
    chk("R8", "irq", {31'd0, irq}, {31'd0, m_pend});
  endtask

  task automatic model_update();
    bit full_b, empty_b;
    full_b = q.size() == DEPTH;
    empty_b = q.size() == 0;
    if (!rst_n) begin
      q.delete(); wp = 0; rp = 0; m_pend = 0; m_mask = 5'h1F;
      return;
    end
    m_pend = (reg_wen && reg_addr == 6'h18 && reg_wdata[0]) ? 1'b0 : (m_pend || (!empty_b && !m_mask[0]));
    if (reg_wen && reg_addr == 6'h1C) m_mask = reg_wdata[4:0];
    if (reg_wen && reg_addr == 6'h10 && reg_wdata == 0) begin
      q.delete(); wp = 0; rp = 0;
    end else begin
      if (reg_wen && reg_addr == 6'h0C && reg_wdata[0] && !empty_b) begin
        void'(q.pop_front()); rp = (rp + 1) % DEPTH;
      end
      if (push_valid && !full_b) begin
        q.push_back({push_id, push_msg}); wp = (wp + 1) % DEPTH;
      end
    end
  endtask

  task automatic step(input bit pv, input logic [7:0] pid, input logic [63:0] pm,
                      input bit we, input logic [5:0] a, input logic [31:0] wd);
    push_valid = pv; push_id = pid; push_msg = pm;
    reg_wen = we; reg_addr = a; reg_wdata = wd;
    #1;
    if (rst_n) compare();
    @(posedge clk);
    #1;
    model_update();
    @(negedge clk);
  endtask

  task automatic rd(input logic [5:0] a);
    step(0, 0, 0, 0, a, 0);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    step(0, 0, 0, 1, a, d);
  endtask

  task automatic push(input logic [7:0] id, input logic [63:0] m, input logic [5:0] a);
    step(1, id, m, 0, a, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    // R9: reset state of every register
    rd(6'h14); rd(6'h18); rd(6'h1C); rd(6'h00);
    // R5
    rd(6'h24);
    // R7: masked source, push does not raise pending
    push(8'h11, 64'h0123_4567_89AB_CDEF, 6'h18);
    rd(6'h18); rd(6'h00); rd(6'h04); rd(6'h08);
    // R7/R8: unmask, pending rises
    wr(6'h1C, 32'h0000_001E);
    rd(6'h18); rd(6'h18);
    // R1: fill to full, then refused push
    push(8'h22, 64'h1111_2222_3333_4444, 6'h14);
    push(8'h33, 64'h5555_6666_7777_8888, 6'h14);
    push(8'h44, 64'h9999_AAAA_BBBB_CCCC, 6'h14);
    push(8'h55, 64'hDEAD_BEEF_DEAD_BEEF, 6'h14);
    rd(6'h14); rd(6'h00);
    // R3: trigger with bit 0 clear is ignored
    wr(6'h0C, 32'h0000_0002);
    rd(6'h00); rd(6'h14);
    // R10: full with pop and push together, push refused
    step(1, 8'h66, 64'h1, 1, 6'h0C, 1);
    rd(6'h14); rd(6'h00); rd(6'h08);
    // R10: push and pop together when not full
    step(1, 8'h77, 64'h7777, 1, 6'h0C, 1);
    rd(6'h14); rd(6'h04);
    // R8: clear while entries remain, sets again
    wr(6'h18, 1);
    rd(6'h18); rd(6'h18);
    // R3: drain past empty
    for (int i = 0; i < DEPTH + 1; i++) begin
      wr(6'h0C, 1);
      rd(6'h00);
    end
    rd(6'h14);
    wr(6'h18, 1);
    rd(6'h18); rd(6'h18);
    // R6: non-zero write ignored, zero write wins over push
    push(8'h88, 64'h8888, 6'h14);
    push(8'h99, 64'h9999, 6'h14);
    wr(6'h10, 32'h0000_0001);
    rd(6'h14);
    step(1, 8'hAA, 64'hAAAA, 1, 6'h10, 0);
    rd(6'h14); rd(6'h00);
    wr(6'h18, 1);
    rd(6'h18);
    // R7: mask back on with entries, pending stays low after clear
    push(8'hBB, 64'hBBBB, 6'h14);
    wr(6'h1C, 32'hFFFF_FFFF);
    rd(6'h1C);
    wr(6'h18, 1);
    rd(6'h18); rd(6'h18);
    wr(6'h1C, 0);
    // R1/R3/R4: wrap the pointers several times
    for (int i = 0; i < 3 * DEPTH; i++) begin
      step(1, 8'(i), 64'(i * 64'h1_0001), 0, 6'h14, 0);
      wr(6'h0C, 1);
    end
    // Random mix, every requirement
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] a;
      logic [31:0] d;
      bit we;
      case ($urandom % 9)
        0: a = 6'h00; 1: a = 6'h04; 2: a = 6'h08; 3: a = 6'h0C; 4: a = 6'h10;
        5: a = 6'h14; 6: a = 6'h18; 7: a = 6'h1C; default: a = 6'h24;
      endcase
      we = ($urandom % 10) < 4;
      d = $urandom;
      if (a == 6'h10 && ($urandom % 4) == 0) d = 0;
      if (a == 6'h1C) d[0] = ($urandom % 4) == 0;
      step(($urandom % 2) == 1, 8'($urandom), {$urandom, $urandom}, we, a, d);
    end
    finish_run();
  end
endmodule